// File: doc/BRIEF.md
# Slow Idle Clock Divider

This block generates the clock enables that pace a processor core and its clocked peripherals. In normal running every cycle is a core cycle. An idle command stops the core and waits for an interrupt. The command either selects plain idle or carries a divisor code for slow idle. In slow idle the core keeps a slowed clock. The serial clock, clock output and timer tick enables are slowed by the same ratio.

Any unmasked interrupt ends idle. A one-cycle pending pulse then tells the core to service the interrupt and resume at the instruction after the idle command. A wake from plain idle takes effect on the next cycle. A wake from slow idle waits for the next boundary of the divided clock, so no divided period is cut short. DMA cycle-steal requests are granted in every mode.

The divider counter is 7 bits wide, counts from reset and never restarts. A slow-idle boundary is a cycle in which the counter value modulo the divisor equals divisor minus one.

Top module: `slow_idle_clkgen`

## Requirements
- R1: Reset gives the running mode. After reset, `idle_o` and `wake_pend_o` are 0, and `core_en_o` and `clkout_en_o` are 1.
- R2: `idle_req_i` is sampled while running. If `idle_plain_i` is 1, the block enters plain idle on the next cycle. In plain idle, `idle_o` is 1, `core_en_o` is 0 and `clkout_en_o` stays 1 every cycle.
- R3: `idle_req_i` is sampled while running. If `idle_plain_i` is 0, the block enters slow idle with the divisor taken from `idle_div_i`: 00 gives 16, 01 gives 32, 10 gives 64 and 11 gives 128. In slow idle, `core_en_o` and `clkout_en_o` are 1 only in boundary cycles. A boundary cycle is one where the cycles since reset, modulo the divisor, equal divisor minus one.
- R4: `sclk_en_o` is 1 on every `SCLK_DIV`-th base tick. `timer_en_o` is 1 on every `TMR_DIV`-th base tick. The base tick is the `clkout_en_o` pulse, so both enables are slowed by the same ratio in slow idle. Both prescalers are 0 after reset.
- R5: In plain idle, an unmasked interrupt returns the block to running on the next cycle. In that first running cycle, `wake_pend_o` is 1 for exactly one cycle.
- R6: In slow idle, an unmasked interrupt is latched, so a one-cycle pulse is enough. Running resumes in the cycle after the first boundary cycle at or after the interrupt, so the wake takes at most n cycles. `wake_pend_o` pulses for one cycle when running resumes.
- R7: An interrupt whose `irq_mask_i` bit is 1 neither wakes the block nor is latched.
- R8: `dma_gnt_o` equals `dma_req_i` delayed by one cycle, in every mode.
- R9: `idle_req_i` has no effect while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idle_req_i | input | 1 | Idle command strobe |
| idle_plain_i | input | 1 | 1 selects plain idle |
| idle_div_i | input | 2 | Slow-idle divisor code |
| irq_i | input | N_IRQ | Interrupt requests |
| irq_mask_i | input | N_IRQ | 1 masks the matching interrupt |
| dma_req_i | input | 1 | Cycle-steal request |
| core_en_o | output | 1 | Core clock enable |
| clkout_en_o | output | 1 | Clock output enable (base tick) |
| sclk_en_o | output | 1 | Serial clock enable |
| timer_en_o | output | 1 | Timer tick enable |
| idle_o | output | 1 | Block is in plain or slow idle |
| wake_pend_o | output | 1 | Interrupt to service after wake |
| dma_gnt_o | output | 1 | Cycle-steal grant |

## Verification
The hardest case to reach is a short interrupt pulse that arrives in slow idle well before a boundary and is gone by the time the boundary comes. Only the latch carries the wake in that case. The stimulus enters slow idle with each divisor code and pulses an unmasked interrupt for a single cycle at varied offsets within the period. It then measures the cycles until `idle_o` falls against the divisor. Random phases add masked interrupts and idle commands issued during idle on top of this.

// File: rtl/sic_pkg.sv
package sic_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_SLOW = 2'd2
  } sic_mode_e;

  localparam int unsigned CODE_W  = 2;
  localparam int unsigned LOG2_LO = 4;                          // divide-by-16 floor
  localparam int unsigned CNT_W   = LOG2_LO + (1 << CODE_W) - 1; // 7 bits, covers 128

  function automatic logic [CNT_W-1:0] period_mask(input logic [CODE_W-1:0] code);
    logic [CNT_W:0] one_hot;
    one_hot = (CNT_W+1)'(1) << (LOG2_LO + int'(code));
    return CNT_W'(one_hot - (CNT_W+1)'(1));
  endfunction
endpackage

// File: rtl/sic_divider.sv
module sic_divider
  import sic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              boundary_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  // free-running: never restarted, so a period is never cut short
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(1);
  end

  assign mask       = period_mask(code_i);
  assign boundary_o = (cnt_q & mask) == mask;
endmodule

// File: rtl/sic_prescaler.sv
module sic_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic en_o
);
  localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + W'(1);
  end

  assign en_o = tick_i && (cnt_q == LAST);

  // R4
  prescale_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |=> !en_o);
endmodule

// File: rtl/slow_idle_clkgen.sv
module slow_idle_clkgen
  import sic_pkg::*;
#(
  parameter int unsigned N_IRQ    = 4,
  parameter int unsigned SCLK_DIV = 4,
  parameter int unsigned TMR_DIV  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_req_i,
  input  logic              idle_plain_i,
  input  logic [CODE_W-1:0] idle_div_i,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic [N_IRQ-1:0]  irq_mask_i,
  input  logic              dma_req_i,
  output logic              core_en_o,
  output logic              clkout_en_o,
  output logic              sclk_en_o,
  output logic              timer_en_o,
  output logic              idle_o,
  output logic              wake_pend_o,
  output logic              dma_gnt_o
);
  sic_mode_e         mode_q, mode_d;
  logic [CODE_W-1:0] code_q;
  logic              pend_q, pend_d;
  logic              wp_d;
  logic              boundary, base_tick, wake_hit;

  sic_divider u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .code_i     (code_q),
    .boundary_o (boundary)
  );

  assign wake_hit  = |(irq_i & ~irq_mask_i);
  assign base_tick = (mode_q == MODE_SLOW) ? boundary : 1'b1;

  always_comb begin
    mode_d = mode_q;
    pend_d = pend_q;
    wp_d   = 1'b0;
    unique case (mode_q)
      MODE_RUN:  if (idle_req_i) mode_d = idle_plain_i ? MODE_IDLE : MODE_SLOW;
      MODE_IDLE: if (wake_hit) begin
        mode_d = MODE_RUN;
        wp_d   = 1'b1;
      end
      MODE_SLOW: begin
        // wake only on a divided-clock boundary
        if ((wake_hit || pend_q) && boundary) begin
          mode_d = MODE_RUN;
          wp_d   = 1'b1;
          pend_d = 1'b0;
        end else begin
          pend_d = pend_q || wake_hit;
        end
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_RUN;
      code_q      <= '0;
      pend_q      <= 1'b0;
      wake_pend_o <= 1'b0;
      dma_gnt_o   <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      pend_q      <= pend_d;
      wake_pend_o <= wp_d;
      dma_gnt_o   <= dma_req_i; // cycle steals granted in every mode
      if (mode_q == MODE_RUN && idle_req_i) code_q <= idle_div_i;
    end
  end

  assign core_en_o   = (mode_q == MODE_IDLE) ? 1'b0 : base_tick;
  assign clkout_en_o = base_tick;
  assign idle_o      = (mode_q != MODE_RUN);

  sic_prescaler #(.DIV(SCLK_DIV)) u_sclk_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (base_tick),
    .en_o   (sclk_en_o)
  );

  sic_prescaler #(.DIV(TMR_DIV)) u_tmr_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (base_tick),
    .en_o   (timer_en_o)
  );

  // R5
  plain_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_IDLE && wake_hit) |=> (!idle_o && wake_pend_o));

  // R7
  masked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_IDLE && !wake_hit) |=> (mode_q == MODE_IDLE));

  // R6
  slow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SLOW && !boundary) |=> (mode_q == MODE_SLOW));

  // R3
  slow_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SLOW && core_en_o && !wake_hit && !pend_q) |=> !core_en_o);

  // R8
  dma_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_i |=> dma_gnt_o);
endmodule

// File: tb/slow_idle_clkgen_tb.sv
`timescale 1ns/1ps
module slow_idle_clkgen_tb;
  localparam int N_IRQ = 4, SCLK_DIV = 4, TMR_DIV = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic idle_req = 0, idle_plain = 0, dma_req = 0;
  logic [1:0] idle_div = 0;
  logic [N_IRQ-1:0] irq = 0, irq_mask = 0;
  logic core_en, clkout_en, sclk_en, timer_en, idle, wake_pend, dma_gnt;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  slow_idle_clkgen #(.N_IRQ(N_IRQ), .SCLK_DIV(SCLK_DIV), .TMR_DIV(TMR_DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .idle_req_i(idle_req), .idle_plain_i(idle_plain),
    .idle_div_i(idle_div), .irq_i(irq), .irq_mask_i(irq_mask), .dma_req_i(dma_req),
    .core_en_o(core_en), .clkout_en_o(clkout_en), .sclk_en_o(sclk_en),
    .timer_en_o(timer_en), .idle_o(idle), .wake_pend_o(wake_pend), .dma_gnt_o(dma_gnt));

  // reference model built from the requirements: 0 run, 1 plain idle, 2 slow idle
  int m_mode, m_div, m_cnt, m_sc, m_tc;
  bit m_pend, m_wp, m_gnt;

  function automatic int divisor(input int code);
    return 16 << code;
  endfunction

  function automatic bit exp_tick();
    if (m_mode == 2) return (m_cnt % divisor(m_div)) == divisor(m_div) - 1;
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode <= 0; m_div <= 0; m_cnt <= 0; m_sc <= 0; m_tc <= 0;
      m_pend <= 0; m_wp <= 0; m_gnt <= 0;
    end else begin
      bit tick, hit;
      tick = exp_tick();
      hit  = |(irq & ~irq_mask);
      m_cnt <= (m_cnt + 1) % 128;
      m_gnt <= dma_req;
      m_wp  <= 0;
      if (tick) begin
        m_sc <= (m_sc + 1) % SCLK_DIV;
        m_tc <= (m_tc + 1) % TMR_DIV;
      end
      case (m_mode)
        0: if (idle_req) begin m_mode <= idle_plain ? 1 : 2; m_div <= idle_div; end
        1: if (hit) begin m_mode <= 0; m_wp <= 1; end
        default: if ((hit || m_pend) && tick) begin
                   m_mode <= 0; m_wp <= 1; m_pend <= 0;
                 end else m_pend <= m_pend || hit;
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit t;
    t = exp_tick();
    check(core_en == ((m_mode == 1) ? 1'b0 : t), "R2/R3 core_en_o", core_en, (m_mode == 1) ? 0 : t);
    check(clkout_en == t, "R3 clkout_en_o", clkout_en, t);
    check(sclk_en == (t && m_sc == SCLK_DIV - 1), "R4 sclk_en_o", sclk_en, t && m_sc == SCLK_DIV - 1);
    check(timer_en == (t && m_tc == TMR_DIV - 1), "R4 timer_en_o", timer_en, t && m_tc == TMR_DIV - 1);
    check(idle == (m_mode != 0), "R2/R9 idle_o", idle, m_mode != 0);
    check(wake_pend == m_wp, "R5/R6 wake_pend_o", wake_pend, m_wp);
    check(dma_gnt == m_gnt, "R8 dma_gnt_o", dma_gnt, m_gnt);
  endtask

  task automatic cyc();
    @(negedge clk);
    compare_all();
  endtask

  task automatic enter_idle(input bit plain, input int code);
    idle_req = 1; idle_plain = plain; idle_div = 2'(code);
    cyc();
    idle_req = 0;
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1d1e));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    check(!idle && !wake_pend && core_en && clkout_en, "R1 reset", {idle, wake_pend, core_en, clkout_en}, 4'b0011);
    compare_all();
    for (int i = 0; i < 20; i++) begin dma_req = 1'($urandom); cyc(); end

    // R2 plain idle, R7 masked irq, R9 ignored command, R5 wake
    enter_idle(1, 0);
    check(idle && !core_en && clkout_en, "R2 plain idle", {idle, core_en, clkout_en}, 3'b101);
    irq = 4'b0010; irq_mask = 4'b0010; cyc(); cyc();
    check(idle, "R7 masked irq held idle", idle, 1);
    irq = 0; idle_req = 1; idle_plain = 0; cyc(); idle_req = 0; cyc();
    check(idle && !core_en, "R9 idle_req in idle", core_en, 0);
    irq = 4'b0100; irq_mask = 0; cyc(); irq = 0;
    check(!idle && wake_pend && core_en, "R5 plain wake", {idle, wake_pend, core_en}, 3'b011);
    cyc();
    check(!wake_pend, "R5 pend one cycle", wake_pend, 0);

    // R3 / R6 slow idle for each code, single-cycle irq at varied offsets
    for (int code = 0; code < 4; code++) begin
      for (int rep = 0; rep < 3; rep++) begin
        int n, wait_c, lat;
        n = divisor(code);
        enter_idle(0, code);
        wait_c = int'($urandom % (2 * n));
        for (int i = 0; i < wait_c; i++) begin
          irq = (i % 7 == 3) ? 4'b1000 : 4'b0000; irq_mask = 4'b1000; // masked, R7
          dma_req = 1'($urandom);
          cyc();
        end
        irq_mask = 0;
        check(idle, "R7 slow idle unmasked-free", idle, 1);
        irq = 4'b0001; cyc(); irq = 0; lat = 1;
        while (idle && lat <= n + 1) begin cyc(); lat++; end
        check(lat <= n, "R6 slow wake latency", lat, n);
        check(wake_pend, "R6 wake pend", wake_pend, 1);
        cyc();
      end
    end

    // random mix
    for (int i = 0; i < 20000; i++) begin
      idle_req   = ($urandom % 25) == 0;
      idle_plain = ($urandom % 3) == 0;
      idle_div   = 2'($urandom);
      irq        = ($urandom % 60) == 0 ? N_IRQ'($urandom) : '0;
      irq_mask   = N_IRQ'($urandom);
      dma_req    = 1'($urandom);
      cyc();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule